// File: doc/BRIEF.md
# Processor Bus Cycle Sequencer with Wait States

This block times a single processor bus transfer. Once a request is accepted, it steps through four fixed clock states, T1, T2, T3 and T4. Between T3 and T4 it can stretch the transfer with any number of wait states, TW. On the core side, each request gives the direction (read or write), the space (memory or I/O), the width (byte or word) and a two-bit segment code. On the bus side, the block drives active-low read and write strobes, an active-low upper-byte enable, a transmit/receive direction level, a two-bit segment status code and an address-latch pulse. It also drives busy and done indications back to the core.

The number of wait states comes from two sources. A programmable wait count is sampled when the request is accepted. A ready input can hold the cycle longer. T4 follows only when the count has run out and ready is high. With no waits, a transfer lasts four clocks, and each wait state adds exactly one clock.

The state machine has six states: IDLE, T1, T2, T3, TW and T4. Its transitions are:
- IDLE goes to T1 on a request.
- T1 goes to T2, and T2 goes to T3.
- T3 goes to TW while the count is non-zero or ready is low. Otherwise it goes to T4.
- TW stays in TW under the same condition. Otherwise it goes to T4.
- T4 goes to T1 if a new request is present. Otherwise it goes to IDLE.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset and while IDLE: rd_n=1, wr_n=1, bhe_n=1, dt_r=0, seg_sts=00, ale=0, busy=0, done=0.
- R2: With ready high, a cycle with wait count N occupies exactly 4+N clocks. The states run T1, T2, T3, then N TW states, then T4.
- R3: A clock in T3 or TW in which ready is low always leads to TW. T4 follows the first T3/TW clock in which the remaining count is zero and ready is high. So with ready low for the first K decision clocks, the cycle has max(N,K) wait states.
- R4: ale is high during T1 only.
- R5: For a read, rd_n is low from T2 through the last TW, and wr_n stays high. For a write, wr_n is low over the same span, and rd_n stays high. Both strobes are high in T1 and T4.
- R6: seg_sts is 10 for an I/O access. For a memory access it repeats the request's segment code: 00 extra, 01 stack, 10 code, 11 data.
- R7: dt_r is 1 for a write and 0 for a read. bhe_n is 0 for a word and 1 for a byte. dt_r, bhe_n and seg_sts are set in T1 and held unchanged through T4.
- R8: busy is high from T1 through T4. done is high for exactly one clock, in T4.
- R9: A request is taken only in IDLE or T4. A request held during T1..TW has no effect on the running cycle. A request present in T4 starts its T1 on the very next clock.
- R10: The wait count is sampled at acceptance. Changing wait_cfg later does not alter the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_seg | input | 2 | Segment code for memory accesses |
| wait_cfg | input | WAIT_W | Programmed wait-state count |
| ready | input | 1 | Bus ready, low extends the cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| bhe_n | output | 1 | Active-low upper-byte enable |
| dt_r | output | 1 | Data direction, 1 = transmit |
| seg_sts | output | 2 | Segment status code |
| ale | output | 1 | Address-latch pulse |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench targets the zero-wait path, where a design that always inserts one TW would report five clocks instead of four. It also targets ready-low stretches that are longer than the programmed count, where a sequencer that checks only the count would reach T4 early. It holds a request during a cycle and changes wait_cfg mid-cycle, which exposes a block that restarts T1 or reloads its counter on the wrong edge. It chains a request into T4, where a design that drops back to IDLE first would lose a clock. Every clock of every cycle compares the full output vector, so a strobe released one state late, or status that slips before T4, shows up as a mismatch.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } bstate_t;

    typedef struct packed {
        logic       write;
        logic       io;
        logic       word;
        logic [1:0] seg;
    } breq_t;

    typedef struct packed {
        logic       dt;
        logic       bhe_n;
        logic [1:0] sts;
    } bsts_t;

    localparam logic [1:0] STS_IO   = 2'b10;
    localparam logic [1:0] STS_IDLE = 2'b00;

endpackage

// File: rtl/bcs_status_enc.sv
module bcs_status_enc
    import bcs_pkg::*;
(
    input  breq_t rq,
    input  logic  active,
    output bsts_t st
);

    always_comb begin
        if (!active) begin
            st.dt    = 1'b0;
            st.bhe_n = 1'b1;
            st.sts   = STS_IDLE;
        end else begin
            st.dt    = rq.write;
            st.bhe_n = ~rq.word;
            st.sts   = rq.io ? STS_IO : rq.seg;
        end
    end

endmodule

// File: rtl/bcs_wait_ctr.sv
module bcs_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              zero
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // Once exhausted, the count stays at zero until reloaded.
    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && dec && !load) |=> zero);

endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    ready,
    input  logic    cnt_zero,
    output bstate_t state,
    output logic    accept,
    output logic    wait_dec
);

    bstate_t state_q, state_d;
    logic    stretch;

    assign stretch = !cnt_zero || !ready;
    assign accept  = req_valid && ((state_q == ST_IDLE) || (state_q == ST_T4));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        wait_dec = 1'b0;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_T1;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3, ST_TW: begin
                wait_dec = 1'b1;
                state_d  = stretch ? ST_TW : ST_T4;
            end
            ST_T4:   state_d = accept ? ST_T1 : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    assert_fixed_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1) |=> (state_q == ST_T2));

    assert_t2_to_t3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2) |=> (state_q == ST_T3));

    assert_hold_on_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && !ready) |=> (state_q == ST_TW));

    assert_release_to_t4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && ready && cnt_zero) |=> (state_q == ST_T4));

    assert_no_midcycle_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T1 || state_q == ST_T2 || state_q == ST_T3 || state_q == ST_TW)
        |=> (state_q != ST_T1));

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              req_word,
    input  logic [1:0]        req_seg,
    input  logic [WAIT_W-1:0] wait_cfg,
    input  logic              ready,
    output logic              rd_n,
    output logic              wr_n,
    output logic              bhe_n,
    output logic              dt_r,
    output logic [1:0]        seg_sts,
    output logic              ale,
    output logic              busy,
    output logic              done
);

    bstate_t state;
    logic    accept;
    logic    wait_dec;
    logic    cnt_zero;
    breq_t   rq_q;
    bsts_t   st;
    logic    active;
    logic    strobe;

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .cnt_zero  (cnt_zero),
        .state     (state),
        .accept    (accept),
        .wait_dec  (wait_dec)
    );

    bcs_wait_ctr #(.WAIT_W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_cfg),
        .dec      (wait_dec),
        .zero     (cnt_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q <= '0;
        end else if (accept) begin
            rq_q <= '{write: req_write, io: req_io, word: req_word, seg: req_seg};
        end
    end

    bcs_status_enc u_enc (
        .rq     (rq_q),
        .active (active),
        .st     (st)
    );

    always_comb begin
        active = 1'b0;
        strobe = 1'b0;
        ale    = 1'b0;
        done   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_T1: begin
                active = 1'b1;
                ale    = 1'b1;
            end
            ST_T2, ST_T3, ST_TW: begin
                active = 1'b1;
                strobe = 1'b1;
            end
            ST_T4: begin
                active = 1'b1;
                done   = 1'b1;
            end
            default: ;
        endcase
        busy    = active;
        rd_n    = ~(strobe && !rq_q.write);
        wr_n    = ~(strobe &&  rq_q.write);
        bhe_n   = st.bhe_n;
        dt_r    = st.dt;
        seg_sts = st.sts;
    end

    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_status_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ale) |-> $stable({dt_r, bhe_n, seg_sts}));

    assert_done_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/bus_cycle_seq_bench.sv
module bus_cycle_seq_bench;

    localparam int WAIT_W = 4;

    typedef struct packed {
        logic       write;
        logic       io;
        logic       word;
        logic [1:0] seg;
    } rq_t;

    typedef enum int { PH_T1, PH_T2, PH_T3, PH_TW, PH_T4, PH_IDLE } ph_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic              req_io = 1'b0;
    logic              req_word = 1'b0;
    logic [1:0]        req_seg = 2'b00;
    logic [WAIT_W-1:0] wait_cfg = '0;
    logic              ready = 1'b1;
    logic              rd_n, wr_n, bhe_n, dt_r, ale, busy, done;
    logic [1:0]        seg_sts;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    bus_cycle_seq #(.WAIT_W(WAIT_W)) u_bus_cycle_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_io(req_io), .req_word(req_word), .req_seg(req_seg), .wait_cfg(wait_cfg),
        .ready(ready), .rd_n(rd_n), .wr_n(wr_n), .bhe_n(bhe_n), .dt_r(dt_r),
        .seg_sts(seg_sts), .ale(ale), .busy(busy), .done(done)
    );

    // {rd_n, wr_n, bhe_n, dt_r, seg_sts, ale, busy, done}
    function automatic logic [8:0] exp_vec(ph_t ph, rq_t p);
        logic s;
        logic [1:0] sts;
        if (ph == PH_IDLE) return 9'b111_0_00_000;
        s   = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
        sts = p.io ? 2'b10 : p.seg;
        return {~(s && !p.write), ~(s && p.write), ~p.word, p.write, sts,
                (ph == PH_T1), 1'b1, (ph == PH_T4)};
    endfunction

    function automatic logic [8:0] act_vec();
        return {rd_n, wr_n, bhe_n, dt_r, seg_sts, ale, busy, done};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive_req(rq_t p, int w);
        req_valid = 1'b1;
        req_write = p.write;
        req_io    = p.io;
        req_word  = p.word;
        req_seg   = p.seg;
        wait_cfg  = w[WAIT_W-1:0];
    endtask

    task automatic idle_check();
        @(negedge clk);
        check("R1 idle outputs", {23'd0, act_vec()}, {23'd0, exp_vec(PH_IDLE, '0)});
        ready = 1'($urandom);
    endtask

    // The request for p must already be driven before the edge that starts T1.
    task automatic run_cycle(rq_t p, int waits, int nr, bit noise, bit chain, rq_t np, int nwait);
        int nw = (waits > nr) ? waits : nr;
        int total = 4 + nw;
        int busy_cnt = 0;
        ph_t ph;
        for (int k = 0; k < total; k++) begin
            @(negedge clk);
            if (k == 0)               ph = PH_T1;
            else if (k == 1)          ph = PH_T2;
            else if (k == 2)          ph = PH_T3;
            else if (k == total - 1)  ph = PH_T4;
            else                      ph = PH_TW;
            check("R4 R5 R6 R7 R8 cycle outputs", {23'd0, act_vec()}, {23'd0, exp_vec(ph, p)});
            if (busy) busy_cnt++;
            if (k == 0) begin
                if (noise) begin
                    // R9, R10: held request and altered wait count must be ignored
                    req_valid = 1'b1;
                    req_write = 1'($urandom);
                    req_io    = 1'($urandom);
                    req_word  = 1'($urandom);
                    req_seg   = 2'($urandom);
                    wait_cfg  = WAIT_W'($urandom);
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (ph == PH_T3 || ph == PH_TW) ready = ((k - 2) < nr) ? 1'b0 : 1'b1;
            else                            ready = 1'($urandom);
            if (k == total - 1) begin
                if (chain) drive_req(np, nwait);
                else       req_valid = 1'b0;
            end
        end
        check("R2 R3 cycle length", busy_cnt, total);
    endtask

    function automatic rq_t mk(bit w, bit io, bit wd, logic [1:0] sg);
        rq_t r;
        r.write = w; r.io = io; r.word = wd; r.seg = sg;
        return r;
    endfunction

    function automatic rq_t rnd_rq();
        return rq_t'($urandom);
    endfunction

    initial begin
        rq_t cur, nxt;
        int  cw, nwt;
        bit  chained, ch;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {23'd0, act_vec()}, {23'd0, exp_vec(PH_IDLE, '0)});
        rst_n = 1'b1;
        idle_check();

        // R6 R7: data-segment byte read, no waits
        drive_req(mk(0, 0, 0, 2'b11), 0);
        run_cycle(mk(0, 0, 0, 2'b11), 0, 0, 0, 0, '0, 0);
        idle_check();
        // R2: stack word write with two waits -> 6 clocks
        drive_req(mk(1, 0, 1, 2'b01), 2);
        run_cycle(mk(1, 0, 1, 2'b01), 2, 0, 0, 0, '0, 0);
        idle_check();
        // R6: word input from I/O space
        drive_req(mk(0, 1, 1, 2'b00), 1);
        run_cycle(mk(0, 1, 1, 2'b00), 1, 0, 0, 0, '0, 0);
        idle_check();
        // R3: zero count but ready low for three decisions
        drive_req(mk(0, 0, 1, 2'b10), 0);
        run_cycle(mk(0, 0, 1, 2'b10), 0, 3, 0, 0, '0, 0);
        idle_check();
        // R9 R10: noise during cycle, then chained start from T4
        drive_req(mk(1, 0, 0, 2'b00), 3);
        run_cycle(mk(1, 0, 0, 2'b00), 3, 1, 1, 1, mk(0, 1, 0, 2'b11), 0);
        run_cycle(mk(0, 1, 0, 2'b11), 0, 0, 0, 0, '0, 0);
        idle_check();
        // R2: largest wait count
        drive_req(mk(0, 0, 1, 2'b01), 15);
        run_cycle(mk(0, 0, 1, 2'b01), 15, 0, 1, 0, '0, 0);
        idle_check();

        chained = 0;
        cur = rnd_rq();
        cw  = $urandom_range(0, 7);
        for (int i = 0; i < 150; i++) begin
            if (!chained) begin
                idle_check();
                drive_req(cur, cw);
            end
            nxt = rnd_rq();
            nwt = $urandom_range(0, 7);
            ch  = 1'($urandom);
            run_cycle(cur, cw, $urandom_range(0, 4), 1'($urandom), ch, nxt, nwt);
            cur = nxt;
            cw  = nwt;
            chained = ch;
        end
        if (chained) run_cycle(cur, cw, 0, 0, 0, '0, 0);
        idle_check();

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule